// File: doc/BRIEF.md
# Boot Table Loader Engine

This engine brings a system up from a boot table held in word-wide memory. After reset it walks the table one 16-bit word at a time through a read request/response port. It first picks up the program entry address. It then performs a list of register writes, into which timed pauses may be mixed. Finally it copies each program or data section, byte by byte, to a byte-wide memory write port at the destination the section names.

A section whose byte count is zero ends the table. The engine then raises `done` and holds the entry address on its output, so that a sequencer can start the loaded code. If the read port reports an error before that point, for example a read past the end of the store, the engine stops fetching and raises `error`.

All 32-bit fields are stored as two words, most significant word first. Inside a section word, the high byte belongs at the lower byte address. A register address of 0xFFFF is not written to any register: it marks a pause entry, whose value word gives the number of clock cycles to wait.

Top module: `boot_table_loader`

## Requirements
- R1: After reset, `done`, `error`, `reg_wr_en` and `mem_wr_en` are 0 and `rd_addr` is 0. Words are fetched from consecutive word addresses, and `rd_addr` advances by one for each read accepted (`rd_req` and `rd_valid` high in the same cycle).
- R2: The first two words form the 32-bit entry address, most significant word first. It is shown on `entry_addr` once `done` is high.
- R3: The next two words give the number of configuration entries, pauses included. Each entry is an address word followed by a value word. For an ordinary entry, `reg_wr_en` pulses for exactly one cycle with that address and value, in the cycle after the value word is accepted.
- R4: An entry whose address word is 0xFFFF writes no register. If its value word is N, `rd_req` stays low for exactly N cycles after that word is accepted, then fetching resumes. N = 0 gives no gap.
- R5: No register write occurs after the first section byte has been written.
- R6: A section record is a 32-bit byte count, then a 32-bit destination byte address, then the data. Data bytes are written one per `mem_wr_en` pulse, high byte of each word first, to ascending addresses starting at the destination.
- R7: A section with byte count C occupies ceil(C/4)*2 data words. The padding bytes past C are read but never written.
- R8: A byte count of zero sets `done`. `done` then stays high, `entry_addr` stays stable and no further reads are requested.
- R9: A configuration count of zero goes straight to the first section record.
- R10: If `rd_err` is seen on a requested read before the terminator, `error` is set and stays set, `done` stays low and no further reads are requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | output | 1 | Word read request, held until answered |
| rd_addr | output | ADDR_W | Word address of the requested read |
| rd_valid | input | 1 | Read data valid; completes the request |
| rd_err | input | 1 | Read failed or address past end |
| rd_data | input | 16 | Read data word |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_addr | output | 16 | Register write address |
| reg_wr_data | output | 16 | Register write value |
| mem_wr_en | output | 1 | Section byte write strobe |
| mem_wr_addr | output | 32 | Section byte destination address |
| mem_wr_data | output | 8 | Section byte value |
| done | output | 1 | Table fully processed |
| entry_addr | output | 32 | Program entry address |
| error | output | 1 | Read fault before the terminator |

## Verification
Two pairs of functions can fall in the same cycle. A register write strobe can coincide with the request for the next table word. The write of a word's last byte can coincide with the fetch, and even the acceptance, of the following data word. A responder that answers with no wait states provokes both overlaps. Longer response latencies pull them apart again.

The bench parses each table on its own to build queues of the register and byte writes it expects. Every clock it checks that a register strobe appears exactly in the cycle after its value word was accepted, and in no other cycle. Every byte strobe is popped against the byte queue. The bench also counts the silent cycles that follow each pause word.

// File: rtl/bl_pkg.sv
// Package: shared widths, the pause key and the walker state encoding.
// Assumes a 16-bit table word, 32-bit multi-word fields, byte-wide sections.
package bl_pkg;
    localparam int HALF_W = 16;
    localparam int FULL_W = 32;
    localparam int BYTE_W = 8;
    localparam logic [HALF_W-1:0] PAUSE_KEY = 16'hFFFF;

    typedef enum logic [3:0] {
        ST_ENT_HI, ST_ENT_LO, ST_NCF_HI, ST_NCF_LO,
        ST_CFG_A,  ST_CFG_V,  ST_WAIT,
        ST_LEN_HI, ST_LEN_LO, ST_DST_HI, ST_DST_LO,
        ST_BODY,   ST_FIN,    ST_FAULT
    } bl_state_t;
endpackage

// File: rtl/bl_fetch.sv
// Word fetcher: turns a "want a word" request into the read port handshake
// and walks the word address. Assumes one read in flight, answered by
// rd_valid or rd_err in the cycle it completes (request held until then).
module bl_fetch #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              want,
    input  logic              rd_valid,
    input  logic              rd_err,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              take,
    output logic              fault
);
    assign rd_req = want;
    assign take   = want && rd_valid && !rd_err;
    assign fault  = want && rd_err;

    // Advance the word pointer on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n)    rd_addr <= '0;
        else if (take) rd_addr <= rd_addr + 1'b1;
    end

    p_word_stride_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (rd_addr == $past(rd_addr) + 1'b1));
endmodule

// File: rtl/bl_delay.sv
// Pause timer: loaded with N, stays busy for exactly N cycles, and flags
// the last busy cycle. A load of zero leaves it idle.
module bl_delay #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] count,
    output logic             busy,
    output logic             expire
);
    logic [CNT_W-1:0] rem;

    // Count the remaining pause cycles down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         rem <= '0;
        else if (load)      rem <= count;
        else if (rem != '0) rem <= rem - 1'b1;
    end

    assign busy   = (rem != '0);
    assign expire = (rem == CNT_W'(1));
endmodule

// File: rtl/bl_emit.sv
// Byte emitter: takes one section word plus how many of its bytes are real
// (0 to 2) and writes them high byte first, one per cycle, at a running
// byte address. It can accept the next word while writing its last byte.
module bl_emit
    import bl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_load,
    input  logic [FULL_W-1:0] sec_base,
    input  logic              word_load,
    input  logic [HALF_W-1:0] word,
    input  logic [1:0]        nbytes,
    output logic              ready,
    output logic              mem_wr_en,
    output logic [FULL_W-1:0] mem_wr_addr,
    output logic [BYTE_W-1:0] mem_wr_data
);
    logic [HALF_W-1:0] hold;
    logic [1:0]        pend;
    logic              sel_lo;

    // Running destination address: set per section, step per byte written.
    always_ff @(posedge clk) begin
        if (!rst_n)          mem_wr_addr <= '0;
        else if (sec_load)   mem_wr_addr <= sec_base;
        else if (pend != '0) mem_wr_addr <= mem_wr_addr + 1'b1;
    end

    // Hold the word and track which of its bytes are still due.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold   <= '0;
            pend   <= '0;
            sel_lo <= 1'b0;
        end else if (word_load) begin
            hold   <= word;
            pend   <= nbytes;
            sel_lo <= 1'b0;
        end else if (pend != '0) begin
            pend   <= pend - 1'b1;
            sel_lo <= 1'b1;
        end
    end

    assign ready       = (pend <= 2'd1);
    assign mem_wr_en   = (pend != '0);
    assign mem_wr_data = sel_lo ? hold[BYTE_W-1:0] : hold[HALF_W-1:BYTE_W];

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && $past(mem_wr_en)) |-> (mem_wr_addr == $past(mem_wr_addr) + 1'b1));
endmodule

// File: rtl/boot_table_loader.sv
// Boot table walker: reads the entry address, runs the register and pause
// entries, copies padded sections, and stops on a zero byte count or a read
// fault. Assumes the table starts at word 0 of the read port.
module boot_table_loader
    import bl_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic              rd_err,
    input  logic [15:0]       rd_data,
    output logic              reg_wr_en,
    output logic [15:0]       reg_wr_addr,
    output logic [15:0]       reg_wr_data,
    output logic              mem_wr_en,
    output logic [31:0]       mem_wr_addr,
    output logic [7:0]        mem_wr_data,
    output logic              done,
    output logic [31:0]       entry_addr,
    output logic              error
);
    localparam int LEN_EXT_W = FULL_W + 1;

    bl_state_t         st;
    logic [HALF_W-1:0] hi_q, cfg_a;
    logic [FULL_W-1:0] ncfg, left_b, left_w;
    logic [FULL_W-1:0] full32;
    logic [LEN_EXT_W-1:0] len_ext;
    logic [1:0]        nb;
    logic              want, take, fault;
    logic              dly_load, dly_busy, dly_expire;
    logic              emit_ready, sec_load, word_load;
    logic              mem_seen;

    assign full32    = {hi_q, rd_data};
    assign len_ext   = {1'b0, full32} + LEN_EXT_W'(3);
    assign nb        = (left_b >= FULL_W'(2)) ? 2'd2 : left_b[1:0];
    assign sec_load  = take && (st == ST_DST_LO);
    assign word_load = take && (st == ST_BODY);
    assign dly_load  = take && (st == ST_CFG_V) && (cfg_a == PAUSE_KEY);

    // Decide in which states a table word is requested.
    always_comb begin
        case (st)
            ST_WAIT, ST_FIN, ST_FAULT: want = 1'b0;
            ST_BODY:                   want = emit_ready;
            default:                   want = 1'b1;
        endcase
    end

    bl_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .want(want), .rd_valid(rd_valid),
        .rd_err(rd_err), .rd_req(rd_req), .rd_addr(rd_addr),
        .take(take), .fault(fault)
    );

    bl_delay #(.CNT_W(HALF_W)) u_delay (
        .clk(clk), .rst_n(rst_n), .load(dly_load), .count(rd_data),
        .busy(dly_busy), .expire(dly_expire)
    );

    bl_emit u_emit (
        .clk(clk), .rst_n(rst_n), .sec_load(sec_load), .sec_base(full32),
        .word_load(word_load), .word(rd_data), .nbytes(nb),
        .ready(emit_ready), .mem_wr_en(mem_wr_en),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    // Walk the table fields and drive register writes and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_ENT_HI;
            hi_q        <= '0;
            cfg_a       <= '0;
            ncfg        <= '0;
            left_b      <= '0;
            left_w      <= '0;
            entry_addr  <= '0;
            reg_wr_en   <= 1'b0;
            reg_wr_addr <= '0;
            reg_wr_data <= '0;
            done        <= 1'b0;
            error       <= 1'b0;
        end else begin
            reg_wr_en <= 1'b0;
            if (fault) begin
                st    <= ST_FAULT;
                error <= 1'b1;
            end else begin
                case (st)
                    ST_ENT_HI, ST_NCF_HI, ST_LEN_HI, ST_DST_HI: begin
                        if (take) begin
                            hi_q <= rd_data;
                            st   <= bl_state_t'(st + 4'd1);
                        end
                    end
                    ST_ENT_LO: if (take) begin
                        entry_addr <= full32;
                        st         <= ST_NCF_HI;
                    end
                    ST_NCF_LO: if (take) begin
                        ncfg <= full32;
                        st   <= (full32 == '0) ? ST_LEN_HI : ST_CFG_A;
                    end
                    ST_CFG_A: if (take) begin
                        cfg_a <= rd_data;
                        st    <= ST_CFG_V;
                    end
                    ST_CFG_V: if (take) begin
                        ncfg <= ncfg - 1'b1;
                        if (cfg_a == PAUSE_KEY && rd_data != '0) begin
                            st <= ST_WAIT;
                        end else begin
                            st <= (ncfg == FULL_W'(1)) ? ST_LEN_HI : ST_CFG_A;
                        end
                        if (cfg_a != PAUSE_KEY) begin
                            reg_wr_en   <= 1'b1;
                            reg_wr_addr <= cfg_a;
                            reg_wr_data <= rd_data;
                        end
                    end
                    ST_WAIT: if (dly_expire) begin
                        st <= (ncfg == '0) ? ST_LEN_HI : ST_CFG_A;
                    end
                    ST_LEN_LO: if (take) begin
                        if (full32 == '0) begin
                            st   <= ST_FIN;
                            done <= 1'b1;
                        end else begin
                            left_b <= full32;
                            left_w <= {len_ext[LEN_EXT_W-1:2], 1'b0};
                            st     <= ST_DST_HI;
                        end
                    end
                    ST_DST_LO: if (take) st <= ST_BODY;
                    ST_BODY: if (take) begin
                        left_b <= left_b - FULL_W'(nb);
                        left_w <= left_w - 1'b1;
                        if (left_w == FULL_W'(1)) st <= ST_LEN_HI;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Remember that section data has started (assertion support only).
    always_ff @(posedge clk) begin
        if (!rst_n)         mem_seen <= 1'b0;
        else if (mem_wr_en) mem_seen <= 1'b1;
    end

    p_pause_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dly_busy |-> !rd_req);
    p_regs_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> !mem_seen);
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(entry_addr) && !rd_req));
    p_fault_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> (error && !done && !rd_req));
endmodule

// File: tb/boot_table_loader_bench.sv
`timescale 1ns/100ps
module boot_table_loader_bench;
    localparam int AW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_req, rd_valid, rd_err;
    logic [AW-1:0] rd_addr;
    logic [15:0] rd_data;
    logic reg_wr_en, mem_wr_en, done, error;
    logic [15:0] reg_wr_addr, reg_wr_data;
    logic [31:0] mem_wr_addr, entry_addr;
    logic [7:0] mem_wr_data;

    always #2.5 clk = ~clk;

    boot_table_loader #(.ADDR_W(AW)) u_boot_table_loader (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_err(rd_err), .rd_data(rd_data),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .done(done), .entry_addr(entry_addr), .error(error)
    );

    int tests = 0, fails = 0;
    logic [15:0] tbl [0:255];
    int kind [0:255];           // 0 plain, 1 register value, 2 pause count
    int tbl_len, lat, err_at, words_read, wcnt, acc_idx;
    bit mon_on = 0, mem_seen, gap_on;
    int gap_n, gap_cnt;
    logic [31:0] q_reg [$];
    logic [39:0] q_mem [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [15:0] w, input int k);
        tbl[tbl_len] = w; kind[tbl_len] = k; tbl_len++;
    endtask
    task automatic put32(input logic [31:0] v);
        put(v[31:16], 0); put(v[15:0], 0);
    endtask
    task automatic new_table(input logic [31:0] entry, input int ncfg);
        tbl_len = 0; q_reg.delete(); q_mem.delete();
        put32(entry); put32(ncfg);
    endtask
    task automatic put_reg(input logic [15:0] a, input logic [15:0] d);
        put(a, 0); put(d, 1); q_reg.push_back({a, d});
    endtask
    task automatic put_pause(input logic [15:0] n);
        put(16'hFFFF, 0); put(n, 2);
    endtask
    task automatic put_section(input logic [31:0] dst, input int nbytes, input int seed);
        int nw;
        nw = ((nbytes + 3) / 4) * 2;
        put32(nbytes); put32(dst);
        for (int w = 0; w < nw; w++) begin
            logic [7:0] hb, lb;
            hb = (2*w < nbytes) ? 8'(seed + 2*w*7) : 8'h00;
            lb = (2*w+1 < nbytes) ? 8'(seed + (2*w+1)*7) : 8'h00;
            put({hb, lb}, 0);
        end
        for (int i = 0; i < nbytes; i++) q_mem.push_back({dst + 32'(i), 8'(seed + i*7)});
    endtask

    // Responder and per-clock reference comparison.
    always @(negedge clk) begin
        if (!mon_on) begin
            rd_valid = 0; rd_err = 0; wcnt = 0;
        end else begin
            bit exp_reg;
            exp_reg = 0;
            if (rd_valid) begin
                words_read++;
                if (kind[acc_idx] == 1) exp_reg = 1;
                if (kind[acc_idx] == 2) begin gap_on = 1; gap_n = tbl[acc_idx]; gap_cnt = 0; end
            end
            if (reg_wr_en || exp_reg) begin
                logic [31:0] e;
                e = (q_reg.size() > 0) ? q_reg[0] : 32'hDEAD_BEEF;
                chk(reg_wr_en && exp_reg && ({reg_wr_addr, reg_wr_data} == e), "R3",
                    "register write", {reg_wr_en, reg_wr_addr, reg_wr_data}, {exp_reg, e});
                if (q_reg.size() > 0) void'(q_reg.pop_front());
                chk(!(reg_wr_en && mem_seen), "R5", "register write after section data",
                    mem_seen, 0);
            end
            if (mem_wr_en) begin
                logic [39:0] e;
                mem_seen = 1;
                e = (q_mem.size() > 0) ? q_mem[0] : 40'hFF_FFFF_FFFF;
                chk({mem_wr_addr, mem_wr_data} == e, "R6/R7", "byte write",
                    {mem_wr_addr, mem_wr_data}, e);
                if (q_mem.size() > 0) void'(q_mem.pop_front());
            end
            if (gap_on) begin
                if (!rd_req) gap_cnt++;
                else begin
                    chk(gap_cnt == gap_n, "R4", "pause length", gap_cnt, gap_n);
                    gap_on = 0;
                end
            end
            rd_valid = 0; rd_err = 0;
            if (rd_req) begin
                if (wcnt >= lat) begin
                    chk(int'(rd_addr) == words_read, "R1", "read address", rd_addr, words_read);
                    if (int'(rd_addr) >= tbl_len || int'(rd_addr) == err_at) rd_err = 1;
                    else begin rd_valid = 1; rd_data = tbl[rd_addr]; acc_idx = int'(rd_addr); end
                    wcnt = 0;
                end else wcnt++;
            end else wcnt = 0;
        end
    end

    task automatic run_case(input int l, input int e_at, input bit ok, input logic [31:0] entry);
        int cyc;
        lat = l; err_at = e_at; words_read = 0; mem_seen = 0; gap_on = 0;
        @(negedge clk); #1 rst_n = 0; mon_on = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!done && !error && !reg_wr_en && !mem_wr_en && rd_addr == '0, "R1",
            "reset state", {done, error, reg_wr_en, mem_wr_en}, 0);
        #1 rst_n = 1; mon_on = 1;
        cyc = 0;
        while (!(done || error) && cyc < 4000) begin @(negedge clk); cyc++; end
        chk(cyc < 4000, "R8/R10", "watchdog", cyc, 4000);
        repeat (4) @(negedge clk);
        chk(!rd_req, "R8/R10", "reads after stop", rd_req, 0);
        chk(done == ok && error == !ok, ok ? "R8" : "R10", "done/error", {done, error}, {ok, !ok});
        if (ok) begin
            chk(entry_addr == entry, "R2", "entry address", entry_addr, entry);
            chk(q_reg.size() == 0, "R3", "register writes left", q_reg.size(), 0);
            chk(q_mem.size() == 0, "R7", "bytes left", q_mem.size(), 0);
            chk(words_read == tbl_len, "R7", "words read", words_read, tbl_len);
        end
        #1 mon_on = 0;
    endtask

    initial begin
        rd_valid = 0; rd_err = 0; rd_data = '0;
        // Case A: registers with a pause, padded sections, zero wait states.
        new_table(32'h0012_3456, 4);
        put_reg(16'h0800, 16'h271C); put_reg(16'h1C80, 16'h0048);
        put_pause(16'd5); put_reg(16'h1C8A, 16'h1003);
        put_section(32'h0000_1000, 5, 3); put_section(32'h0000_2000, 4, 40);
        put32(0);
        run_case(0, -1, 1, 32'h0012_3456);
        // Case B: no configuration entries (R9), tiny sections, slow responder.
        new_table(32'hABCD_0001, 0);
        put_section(32'h8000_0000, 1, 9); put_section(32'h8000_0100, 2, 77);
        put32(0);
        run_case(2, -1, 1, 32'hABCD_0001);
        // Case C: zero-length and one-cycle pauses around a register write.
        new_table(32'hFFFF_FFFE, 3);
        put_pause(16'd0); put_reg(16'h0001, 16'hBEEF); put_pause(16'd1);
        put_section(32'h0000_0040, 8, 100);
        put32(0);
        run_case(1, -1, 1, 32'hFFFF_FFFE);
        // Case D: table ends without terminator, read past end flags a fault.
        new_table(32'h0000_0010, 1);
        put_reg(16'h0002, 16'h0003);
        put_section(32'h0000_0300, 3, 5);
        run_case(0, -1, 0, 32'h0);
        // Case E: read fault injected inside the register list.
        new_table(32'h0000_0020, 3);
        put_reg(16'h0004, 16'h0005); put_reg(16'h0006, 16'h0007); put_reg(16'h0008, 16'h0009);
        put32(0);
        run_case(0, 7, 0, 32'h0);
        chk(q_reg.size() == 2, "R10", "writes skipped after fault", q_reg.size(), 2);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule